// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through or Standard Read Flags

This block is a first-in first-out buffer between two unrelated clock domains. A producer pushes words on the write clock and a consumer takes them on the read clock. Each side keeps its own binary pointer for addressing and publishes a Gray-coded copy. The other side samples that copy through a two-stage synchronizer. The full and empty decisions are made entirely inside the domain that uses them.

A static mode pin selects how the read side behaves. In fall-through mode the oldest word is moved into the output register without any request, and a ready flag marks it as valid. The consumer acknowledges it with the read enable. In standard mode the read-side flag is an active-low empty indication, and each accepted read enable loads the next word into the output register. On the write side the same flag serves both modes. It reads as input-ready in fall-through mode and as active-low full in standard mode. The mode may only change while reset is asserted.

Top module: `dcf_fifo`

## Requirements
- R1: While reset is asserted and after it is released with no writes, `rd_avail` is 0, `wr_room` is 1 and `rd_data` is 0.
- R2: `fwft_mode`=1 selects fall-through behaviour and `fwft_mode`=0 selects standard behaviour. In standard mode a stored word never reaches `rd_data` unless `rd_en` is applied.
- R3: In standard mode, `rd_en` while `rd_avail` is 0 is ignored and `rd_data` keeps its previous word.
- R4: In standard mode, after a write into an empty FIFO, `rd_avail` is still 0 after the first rising `rd_clk` edge and is 1 after the second.
- R5: In standard mode, `rd_en` at a rising `rd_clk` edge with `rd_avail`=1 loads the oldest unread word into `rd_data` on that edge. With `rd_avail`=0 no word is taken.
- R6: In fall-through mode, a word written into an empty FIFO appears on `rd_data` at the third rising `rd_clk` edge after the write, and `rd_avail` rises on that same edge. It is still 0 after the second edge.
- R7: In fall-through mode, `rd_en` while `rd_avail` is 0 is ignored. While `rd_avail` is 1 and `rd_en` is 0, the word and the flag both hold.
- R8: After 2^AW words are written and none are read, `wr_room` is 0 and further writes are ignored. No extra word is ever read out.
- R9: After a read frees a location in a full FIFO, `wr_room` is still 0 after the first rising `wr_clk` edge and is 1 after the second.
- R10: Words leave in the order they were written, including across the pointer wrap.
- R11: Pointers cross domains in Gray code, changing at most one bit per clock. After the pointers wrap, a drained FIFO again shows `rd_avail`=0 and `wr_room`=1.
- R12: In fall-through mode, holding `rd_en` with more words stored replaces `rd_data` with the next word on every read edge. `rd_avail` falls on the edge that takes the last word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| arst_n | input | 1 | Asynchronous active-low reset for both sides |
| fwft_mode | input | 1 | 1 = fall-through, 0 = standard; static outside reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| wr_room | output | 1 | Input-ready (fall-through) / not-full (standard) |
| rd_en | input | 1 | Read request or acknowledge |
| rd_data | output | DW | Output register |
| rd_avail | output | 1 | Output-ready (fall-through) / not-empty (standard) |

## Verification
A write becomes visible on the read side two `rd_clk` edges later in standard mode and three edges later in fall-through mode. A freed slot becomes visible on the write side two `wr_clk` edges after the read. The bench counts those exact edges from the edge that carried the stimulus, and samples one nanosecond after each edge. The flag is checked low on the edge before the due edge and high on the due edge itself. The read clock is offset from the write clock, so every sample falls between the edges of both clocks. Loads into the output register are checked right after the read edge that caused them.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  typedef enum logic {
    RD_STANDARD  = 1'b0,
    RD_FALLTHRU  = 1'b1
  } rd_mode_e;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer; also used as reset release synchronizer.
module dcf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_sync,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          we,
  output logic          room
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] WRAP_MASK = PW'(3) << (AW - 1);

  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d;
  logic          full, accept;

  always_comb begin
    full   = (gray_q == (rgray_sync ^ WRAP_MASK));
    accept = wr_en & ~full;
    bin_d  = bin_q + PW'(accept);
    gray_d = PW'(dcf_pkg::bin_to_gray(32'(bin_d)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (accept) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign wgray = gray_q;
  assign waddr = bin_q[AW-1:0];
  assign we    = accept;
  assign room  = ~full;

  // R8: a refused write leaves the pointer where it was
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !room) |=> $stable(bin_q));
  // R11: published pointer changes by at most one bit
  p_wgray_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gray_q ^ $past(gray_q)));
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_sync,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] dout,
  output logic          avail
);
  localparam int PW = AW + 1;

  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d;
  logic [DW-1:0] dout_q, dout_d;
  logic          ready_q, ready_d;
  logic          stored, load;

  always_comb begin
    stored = (gray_q != wgray_sync);
    if (fwft) load = stored && (!ready_q || rd_en);
    else      load = stored && rd_en;
    bin_d  = bin_q + PW'(load);
    gray_d = PW'(dcf_pkg::bin_to_gray(32'(bin_d)));
    dout_d = load ? mem_rdata : dout_q;
    if (!fwft)      ready_d = 1'b0;
    else if (load)  ready_d = 1'b1;
    else if (rd_en) ready_d = 1'b0;
    else            ready_d = ready_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (load) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else if (load) dout_q <= dout_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_d;
  end

  assign raddr = bin_q[AW-1:0];
  assign rgray = gray_q;
  assign dout  = dout_q;
  assign avail = fwft ? ready_q : stored;

  // R3: standard-mode read on empty keeps the output word
  p_ignore_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && rd_en && !avail) |=> $stable(dout_q));
  // R5: nothing taken from memory while it holds no word
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stored && !(fwft && !ready_q)) |=> $stable(bin_q));
  // R7: fall-through word without acknowledge holds
  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && avail && !rd_en) |=> (avail && $stable(dout_q)));
  // R11: published pointer changes by at most one bit
  p_rgray_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gray_q ^ $past(gray_q)));
endmodule

// File: rtl/dcf_fifo.sv
`timescale 1ns/1ps
module dcf_fifo #(
  parameter int AW        = 4,
  parameter int DW        = 16,
  parameter int SYNC_LEN  = 2
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          arst_n,
  input  logic          fwft_mode,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_room,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_avail
);
  localparam int PW = AW + 1;

  dcf_pkg::rd_mode_e mode;
  logic          wrst_n, rrst_n, fwft;
  logic [PW-1:0] wgray, rgray, wgray_rs, rgray_ws;
  logic [AW-1:0] waddr, raddr;
  logic          we;
  logic [DW-1:0] mem_rdata;

  assign mode = dcf_pkg::rd_mode_e'(fwft_mode);
  assign fwft = (mode == dcf_pkg::RD_FALLTHRU);

  dcf_sync #(.W(1), .STAGES(SYNC_LEN)) u_wrst (
    .clk(wr_clk), .rst_n(arst_n), .d(1'b1), .q(wrst_n));
  dcf_sync #(.W(1), .STAGES(SYNC_LEN)) u_rrst (
    .clk(rd_clk), .rst_n(arst_n), .d(1'b1), .q(rrst_n));

  dcf_sync #(.W(PW), .STAGES(SYNC_LEN)) u_r2w (
    .clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_ws));
  dcf_sync #(.W(PW), .STAGES(SYNC_LEN)) u_w2r (
    .clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_rs));

  dcf_wr_side #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(wrst_n), .wr_en(wr_en), .rgray_sync(rgray_ws),
    .wgray(wgray), .waddr(waddr), .we(we), .room(wr_room));

  dcf_ram #(.AW(AW), .DW(DW)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata));

  dcf_rd_side #(.AW(AW), .DW(DW)) u_rd (
    .clk(rd_clk), .rst_n(rrst_n), .fwft(fwft), .rd_en(rd_en),
    .wgray_sync(wgray_rs), .mem_rdata(mem_rdata), .raddr(raddr),
    .rgray(rgray), .dout(rd_data), .avail(rd_avail));
endmodule

// File: tb/dcf_fifo_test.sv
`timescale 1ns/1ps
module dcf_fifo_test;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam int NVEC = 8;
  // [31:16] word pushed, [15:0] word expected back, same position
  localparam logic [31:0] VEC [NVEC] = '{
    32'hA5A5_A5A5, 32'h0001_0001, 32'hFFFF_FFFF, 32'h8000_8000,
    32'h1234_1234, 32'h0F0F_0F0F, 32'h7FFE_7FFE, 32'hC3C3_C3C3};

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic arst_n, fwft_mode, wr_en, rd_en;
  logic [DW-1:0] wr_data, rd_data;
  logic wr_room, rd_avail;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 wr_clk = ~wr_clk;
  initial begin
    #0.5;
    forever begin rd_clk = ~rd_clk; #2.5; end
  end

  dcf_fifo #(.AW(AW), .DW(DW)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .arst_n(arst_n), .fwft_mode(fwft_mode),
    .wr_en(wr_en), .wr_data(wr_data), .wr_room(wr_room),
    .rd_en(rd_en), .rd_data(rd_data), .rd_avail(rd_avail));

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic do_reset(input logic m);
    arst_n = 1'b0; fwft_mode = m; wr_en = 0; rd_en = 0; wr_data = '0;
    repeat (3) @(posedge wr_clk);
    #1;
    chk(rd_avail == 0 && wr_room == 1, "R1", {rd_avail, wr_room}, 2'b01);
    @(negedge wr_clk); arst_n = 1'b1;
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
    #1;
  endtask

  task automatic wr_word(input logic [DW-1:0] d);
    @(negedge wr_clk); wr_en = 1; wr_data = d;
    @(posedge wr_clk); #1; wr_en = 0;
  endtask

  task automatic rd_pulse();
    @(negedge rd_clk); rd_en = 1;
    @(posedge rd_clk); #1; rd_en = 0;
  endtask

  task automatic wait_avail();
    for (int n = 0; n < 50 && !rd_avail; n++) begin
      @(posedge rd_clk); #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge wr_clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    // ---------------- standard mode ----------------
    do_reset(1'b0);
    chk(rd_avail == 0 && wr_room == 1 && rd_data == 0, "R1",
        {rd_avail, wr_room, rd_data}, 18'h10000);

    // R4: flag due on the second read edge after the write
    @(negedge wr_clk); wr_en = 1; wr_data = 16'h5A01;
    @(posedge wr_clk); #1; wr_en = 0;
    @(posedge rd_clk); #1;
    chk(rd_avail == 0, "R4", rd_avail, 0);
    @(posedge rd_clk); #1;
    chk(rd_avail == 1, "R4", rd_avail, 1);
    repeat (3) @(posedge rd_clk); #1;
    chk(rd_data == 0, "R2", rd_data, 0);
    rd_pulse();
    chk(rd_data == 16'h5A01, "R5", rd_data, 16'h5A01);
    chk(rd_avail == 0, "R5", rd_avail, 0);
    // R3: reads on empty are ignored
    @(negedge rd_clk); rd_en = 1;
    repeat (3) @(posedge rd_clk); #1; rd_en = 0;
    chk(rd_data == 16'h5A01 && rd_avail == 0, "R3", rd_data, 16'h5A01);

    // R8: fill to depth, then an extra write must be dropped
    for (int i = 0; i < DEPTH; i++) wr_word(16'h1000 + 16'(i));
    chk(wr_room == 0, "R8", wr_room, 0);
    wr_word(16'hDEAD);
    chk(wr_room == 0, "R8", wr_room, 0);
    repeat (4) @(posedge rd_clk); #1;
    // R9: room returns on the second write edge after the read
    @(negedge rd_clk); rd_en = 1;
    @(posedge rd_clk); #1; rd_en = 0;
    chk(rd_data == 16'h1000, "R10", rd_data, 16'h1000);
    @(posedge wr_clk); #1;
    chk(wr_room == 0, "R9", wr_room, 0);
    @(posedge wr_clk); #1;
    chk(wr_room == 1, "R9", wr_room, 1);
    for (int i = 1; i < DEPTH; i++) begin
      rd_pulse();
      chk(rd_data == 16'h1000 + 16'(i), "R10", rd_data, 16'h1000 + 16'(i));
    end
    chk(rd_avail == 0, "R8", rd_avail, 0);

    // vector table across the pointer wrap
    for (int v = 0; v < NVEC; v++) wr_word(VEC[v][31:16]);
    wait_avail();
    for (int v = 0; v < NVEC; v++) begin
      rd_pulse();
      chk(rd_data == VEC[v][15:0], "R10", rd_data, VEC[v][15:0]);
    end
    repeat (4) @(posedge wr_clk); #1;
    chk(rd_avail == 0 && wr_room == 1, "R11", {rd_avail, wr_room}, 2'b01);

    // ---------------- fall-through mode ----------------
    do_reset(1'b1);
    chk(rd_avail == 0 && wr_room == 1, "R1", {rd_avail, wr_room}, 2'b01);
    @(negedge wr_clk); wr_en = 1; wr_data = 16'hBEEF;
    @(posedge wr_clk); #1; wr_en = 0;
    @(posedge rd_clk); #1;
    chk(rd_avail == 0, "R6", rd_avail, 0);
    @(posedge rd_clk); #1;
    chk(rd_avail == 0 && rd_data == 0, "R6", rd_avail, 0);
    @(posedge rd_clk); #1;
    chk(rd_avail == 1 && rd_data == 16'hBEEF, "R6", rd_data, 16'hBEEF);
    repeat (3) @(posedge rd_clk); #1;
    chk(rd_avail == 1 && rd_data == 16'hBEEF, "R7", rd_data, 16'hBEEF);
    rd_pulse();
    chk(rd_avail == 0, "R12", rd_avail, 0);
    rd_pulse(); rd_pulse();
    chk(rd_avail == 0 && rd_data == 16'hBEEF, "R7", rd_data, 16'hBEEF);

    // R12: continuous acknowledge streams words
    wr_word(16'h0A00); wr_word(16'h0A01); wr_word(16'h0A02);
    repeat (4) @(posedge rd_clk); #1;
    chk(rd_avail == 1 && rd_data == 16'h0A00, "R2", rd_data, 16'h0A00);
    @(negedge rd_clk); rd_en = 1;
    for (int i = 1; i < 3; i++) begin
      @(posedge rd_clk); #1;
      chk(rd_avail == 1 && rd_data == 16'h0A00 + 16'(i), "R12",
          rd_data, 16'h0A00 + 16'(i));
    end
    @(posedge rd_clk); #1;
    chk(rd_avail == 0, "R12", rd_avail, 0);
    rd_en = 0;

    finish_run();
  end
endmodule